// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel Controller

This block is the DMA channel that sits beside a SCSI protocol core in a host adapter. Software programs a starting byte count, a starting memory address and a starting descriptor-list address, then issues a command. The start command loads the working copies of those three values, clears the status flags and enables DMA toward the SCSI core. The idle command disables DMA. The blast command raises a blast-complete flag. The abort command sends a one-cycle cancel pulse to the core.

While a transfer runs, the SCSI core asks for data moves over a valid/ready request channel. The channel checks the requested direction against the programmed direction and limits the length to the bytes still owed. It then lowers the working count and raises the working address by the granted amount. Each accepted request is answered one cycle later with an acknowledge and the granted length. The request port is always ready once reset is released, so there is no back-pressure. A request held valid for N cycles counts as N requests.

A level-sensitive host interrupt combines the SCSI core's interrupt with a DMA-done flag. The done flag counts only when its enable bit is set. Status flags are cleared in one of two ways, chosen by a bit in a separate bus-control register: by reading the status register, or by writing ones to it.

Top module: `scsi_dma_chan`

## Requirements
- R1: Register addresses are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list address, 7 working list address, and 8 bus control. A read returns the register value at once, with the command and status registers zero-extended. Writes to addresses 3, 4 and 7 are ignored.
- R2: Writing the command register with bits 1:0 = 3 (start) has these effects at that edge. The start count is copied to the working count, the start address to the working address, and the start list address to the working list address. All six status bits are cleared, and the DMA-enable output is set.
- R3: Command bits 1:0 = 0 (idle) clear the DMA-enable output. A value of 1 (blast) sets status bit 5. A value of 2 (abort) drives the cancel output high for exactly one cycle.
- R4: The host interrupt is a register. Its value equals status bit 4 OR (status bit 3 AND command bit 6), and it follows any change of status or command in the same cycle.
- R5: A rising SCSI core interrupt sets status bit 4. In the same cycle, if command bits 1:0 are 3 and the working count is zero, it also sets status bit 3. A falling SCSI core interrupt clears status bit 4.
- R6: When bus-control bit 24 is 0, a status read returns the current value and then clears status bits 1, 2 and 3. In this mode, writes to the status register have no effect.
- R7: When bus-control bit 24 is 1, a status write clears each of bits 1, 2 and 3 wherever the written value has a one. In this mode, a status read clears nothing.
- R8: An accepted request whose direction matches command bit 7 (1 = device to memory) is granted min(length, working count). The working count drops by the granted length and the working address rises by it. The acknowledge and the granted length appear one cycle after acceptance.
- R9: An accepted request whose direction does not match command bit 7 is acknowledged with a granted length of 0. It leaves both working counters unchanged.
- R10: After reset, the command, status and working count read 0, the working address reads 0xFFFFFFFF, the working list address reads 0xFFFFFFFD, and the host interrupt and DMA-enable outputs are low.
- R11: Addresses 9 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| core_irq | input | 1 | SCSI core interrupt level |
| core_dma_en | output | 1 | DMA enabled toward the SCSI core |
| core_cancel | output | 1 | One-cycle cancel pulse to the SCSI core |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Transfer request ready (high out of reset) |
| xfer_dir | input | 1 | Request direction, 1 = device to memory |
| xfer_len | input | LEN_W | Requested byte count |
| xfer_ack | output | 1 | Request answered (one cycle after acceptance) |
| xfer_grant | output | LEN_W | Granted byte count |
| host_irq | output | 1 | Level-sensitive host interrupt |

## Verification
The assertions assume two things about the inputs. First, software never writes the start count or start address in the same cycle as a start command. Second, the counter-conservation property treats only a start command as a legal reload of the working counters. The stimulus respects both: it uses one register access per cycle and spaces transfer requests apart from register writes. The random phase picks directions and lengths from $urandom. Lengths often exceed the remaining count, so the clamp and the zero-count boundary are reached many times.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int REG_W = 32;
  localparam int AW    = 4;

  localparam logic [AW-1:0] A_CMD  = 4'd0;
  localparam logic [AW-1:0] A_STC  = 4'd1;
  localparam logic [AW-1:0] A_SPA  = 4'd2;
  localparam logic [AW-1:0] A_WBC  = 4'd3;
  localparam logic [AW-1:0] A_WAC  = 4'd4;
  localparam logic [AW-1:0] A_STAT = 4'd5;
  localparam logic [AW-1:0] A_SLA  = 4'd6;
  localparam logic [AW-1:0] A_WLA  = 4'd7;
  localparam logic [AW-1:0] A_BCTL = 4'd8;

  localparam int CMD_DONE_EN = 6;
  localparam int CMD_DIR     = 7;

  localparam int ST_W     = 6;
  localparam int ST_ERR   = 1;
  localparam int ST_ABT   = 2;
  localparam int ST_DONE  = 3;
  localparam int ST_SCSI  = 4;
  localparam int ST_BLAST = 5;

  localparam int BCTL_W1C = 24;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;
endpackage

// File: rtl/dma_xfer_unit.sv
module dma_xfer_unit #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_dir,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cmd_dir,
  input  logic [CNT_W-1:0] wbc,
  output logic             req_ready,
  output logic             accept,
  output logic [LEN_W-1:0] grant_now,
  output logic             ack,
  output logic [LEN_W-1:0] granted
);
  logic             dir_ok;
  logic [CNT_W-1:0] len_ext;

  assign len_ext = CNT_W'(req_len);
  assign dir_ok  = (req_dir == cmd_dir);
  assign accept  = req_valid && req_ready;

  always_comb begin
    if (!dir_ok)            grant_now = '0;
    else if (len_ext <= wbc) grant_now = req_len;
    else                    grant_now = wbc[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      ack       <= 1'b0;
      granted   <= '0;
    end else begin
      req_ready <= 1'b1;
      ack       <= accept;
      granted   <= accept ? grant_now : '0;
    end
  end

  assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (CNT_W'(granted) <= $past(wbc)) && (granted <= $past(req_len)));

  assert_dir_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_dir != cmd_dir)) |=> (ack && granted == '0));
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic scsi_flag_n,
  input  logic done_flag_n,
  input  logic done_en_n,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= scsi_flag_n | (done_flag_n & done_en_n);
  end
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int          LEN_W   = 16,
  parameter logic [31:0] WAC_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] WLA_RST = 32'hFFFF_FFFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             core_irq,
  output logic             core_dma_en,
  output logic             core_cancel,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_ack,
  output logic [LEN_W-1:0] xfer_grant,
  output logic             host_irq
);
  localparam logic [ST_W-1:0] CLR_MASK =
    ST_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

  logic [7:0]       cmd_q, cmd_n;
  logic [REG_W-1:0] stc_q, spa_q, sla_q, wbc_q, wac_q, wla_q, bctl_q;
  logic [REG_W-1:0] wbc_n, wac_n;
  logic [ST_W-1:0]  stat_q, stat_n;
  logic             core_q;
  logic             acc;
  logic [LEN_W-1:0] g_now;

  logic    cmd_wr, stat_wr, stat_rd, w1c_mode, rise, fall;
  dma_op_e op_wr;

  assign cmd_wr   = reg_wr && reg_addr == A_CMD;
  assign stat_wr  = reg_wr && reg_addr == A_STAT;
  assign stat_rd  = reg_rd && reg_addr == A_STAT;
  assign op_wr    = dma_op_e'(reg_wdata[1:0]);
  assign w1c_mode = bctl_q[BCTL_W1C];
  assign rise     = core_irq && !core_q;
  assign fall     = !core_irq && core_q;

  dma_xfer_unit #(.LEN_W(LEN_W), .CNT_W(REG_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(xfer_valid), .req_dir(xfer_dir), .req_len(xfer_len),
    .cmd_dir(cmd_q[CMD_DIR]), .wbc(wbc_q),
    .req_ready(xfer_ready), .accept(acc), .grant_now(g_now),
    .ack(xfer_ack), .granted(xfer_grant)
  );

  assign cmd_n = cmd_wr ? reg_wdata[7:0] : cmd_q;

  always_comb begin
    stat_n = stat_q;
    if (cmd_wr && op_wr == OP_START) stat_n = '0;
    if (cmd_wr && op_wr == OP_BLAST) stat_n[ST_BLAST] = 1'b1;
    if (stat_wr && w1c_mode)  stat_n = stat_n & ~(reg_wdata[ST_W-1:0] & CLR_MASK);
    if (stat_rd && !w1c_mode) stat_n = stat_n & ~CLR_MASK;
    if (fall) stat_n[ST_SCSI] = 1'b0;
    if (rise) begin
      stat_n[ST_SCSI] = 1'b1;
      if (dma_op_e'(cmd_q[1:0]) == OP_START && wbc_q == '0) stat_n[ST_DONE] = 1'b1;
    end
  end

  always_comb begin
    wbc_n = wbc_q;
    wac_n = wac_q;
    if (cmd_wr && op_wr == OP_START) begin
      wbc_n = stc_q;
      wac_n = spa_q;
    end else if (acc) begin
      wbc_n = wbc_q - REG_W'(g_now);
      wac_n = wac_q + REG_W'(g_now);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      stc_q       <= '0;
      spa_q       <= '0;
      sla_q       <= '0;
      wbc_q       <= '0;
      wac_q       <= WAC_RST;
      wla_q       <= WLA_RST;
      bctl_q      <= '0;
      stat_q      <= '0;
      core_q      <= 1'b0;
      core_dma_en <= 1'b0;
      core_cancel <= 1'b0;
    end else begin
      cmd_q  <= cmd_n;
      stat_q <= stat_n;
      wbc_q  <= wbc_n;
      wac_q  <= wac_n;
      core_q <= core_irq;
      if (reg_wr && reg_addr == A_STC)  stc_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_SPA)  spa_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_SLA)  sla_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_BCTL) bctl_q <= reg_wdata;
      if (cmd_wr && op_wr == OP_START)  wla_q  <= sla_q;
      if (cmd_wr && op_wr == OP_START)     core_dma_en <= 1'b1;
      else if (cmd_wr && op_wr == OP_IDLE) core_dma_en <= 1'b0;
      core_cancel <= cmd_wr && op_wr == OP_ABORT;
    end
  end

  dma_irq_merge u_irq (
    .clk(clk), .rst_n(rst_n),
    .scsi_flag_n(stat_n[ST_SCSI]), .done_flag_n(stat_n[ST_DONE]),
    .done_en_n(cmd_n[CMD_DONE_EN]), .irq(host_irq)
  );

  always_comb begin
    unique case (reg_addr)
      A_CMD:   reg_rdata = {24'b0, cmd_q};
      A_STC:   reg_rdata = stc_q;
      A_SPA:   reg_rdata = spa_q;
      A_WBC:   reg_rdata = wbc_q;
      A_WAC:   reg_rdata = wac_q;
      A_STAT:  reg_rdata = {{(REG_W-ST_W){1'b0}}, stat_q};
      A_SLA:   reg_rdata = sla_q;
      A_WLA:   reg_rdata = wla_q;
      A_BCTL:  reg_rdata = bctl_q;
      default: reg_rdata = '0;
    endcase
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op_wr == OP_START) |=> (wbc_q == $past(stc_q) && wac_q == $past(spa_q)
                                       && stat_q == '0 && core_dma_en));

  assert_irq_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (stat_q[ST_SCSI] | (stat_q[ST_DONE] & cmd_q[CMD_DONE_EN])));

  assert_scsi_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> stat_q[ST_SCSI]);

  assert_conserve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && op_wr == OP_START) |=> (wac_q + wbc_q) == $past(wac_q + wbc_q));

  assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && op_wr == OP_ABORT) |=> !core_cancel);
endmodule

// File: tb/scsi_dma_chan_test.sv
module scsi_dma_chan_test;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic core_irq = 1'b0, core_dma_en, core_cancel;
  logic xfer_valid = 1'b0, xfer_ready, xfer_dir = 1'b0, xfer_ack;
  logic [LEN_W-1:0] xfer_len = '0, xfer_grant;
  logic host_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  scsi_dma_chan #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_irq(core_irq), .core_dma_en(core_dma_en), .core_cancel(core_cancel),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dir(xfer_dir),
    .xfer_len(xfer_len), .xfer_ack(xfer_ack), .xfer_grant(xfer_grant),
    .host_irq(host_irq)
  );

  function automatic logic [31:0] exp_grant(logic [31:0] wbc, logic [31:0] len, bit dir_ok);
    if (!dir_ok) return 0;
    return (len < wbc) ? len : wbc;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic xfer(bit dir, logic [LEN_W-1:0] len, output bit ack, output logic [31:0] g);
    @(negedge clk); xfer_valid = 1'b1; xfer_dir = dir; xfer_len = len;
    @(negedge clk); xfer_valid = 1'b0; ack = xfer_ack; g = 32'(xfer_grant);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, g, m_wbc, m_wac, stc, spa;
    bit ack, m_dir;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset values
    peek(4'd0, v); chk("R10 cmd", v, 0);
    peek(4'd3, v); chk("R10 wbc", v, 0);
    peek(4'd4, v); chk("R10 wac", v, 32'hFFFF_FFFF);
    peek(4'd7, v); chk("R10 wla", v, 32'hFFFF_FFFD);
    peek(4'd5, v); chk("R10 stat", v, 0);
    chk("R10 irq", 32'(host_irq), 0);
    chk("R10 dma_en", 32'(core_dma_en), 0);

    // R1 register map, read-only working registers
    wr(4'd1, 32'h100); wr(4'd2, 32'h1000); wr(4'd6, 32'h2000);
    wr(4'd3, 32'h5); wr(4'd4, 32'h7); wr(4'd7, 32'h9);
    peek(4'd1, v); chk("R1 stc", v, 32'h100);
    peek(4'd2, v); chk("R1 spa", v, 32'h1000);
    peek(4'd6, v); chk("R1 sla", v, 32'h2000);
    peek(4'd3, v); chk("R1 wbc write ignored", v, 0);
    peek(4'd4, v); chk("R1 wac write ignored", v, 32'hFFFF_FFFF);
    peek(4'd7, v); chk("R1 wla write ignored", v, 32'hFFFF_FFFD);

    // R2 start, done enable on, direction memory->device
    wr(4'd0, 32'h43);
    peek(4'd3, v); chk("R2 wbc load", v, 32'h100);
    peek(4'd4, v); chk("R2 wac load", v, 32'h1000);
    peek(4'd7, v); chk("R2 wla load", v, 32'h2000);
    chk("R2 dma_en", 32'(core_dma_en), 1);

    // R8 / R9 transfers
    xfer(1'b0, 16'h40, ack, g);
    chk("R8 ack", 32'(ack), 1); chk("R8 grant", g, 32'h40);
    peek(4'd3, v); chk("R8 wbc", v, 32'hC0);
    peek(4'd4, v); chk("R8 wac", v, 32'h1040);
    xfer(1'b1, 16'h10, ack, g);
    chk("R9 ack", 32'(ack), 1); chk("R9 grant", g, 0);
    peek(4'd3, v); chk("R9 wbc", v, 32'hC0);
    xfer(1'b0, 16'h200, ack, g);
    chk("R8 clamp grant", g, 32'hC0);
    peek(4'd3, v); chk("R8 clamp wbc", v, 0);
    peek(4'd4, v); chk("R8 clamp wac", v, 32'h1100);

    // R5 / R4 interrupt with zero count
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk);
    peek(4'd5, v); chk("R5 rise done+scsi", v, 32'h18);
    chk("R4 irq high", 32'(host_irq), 1);
    core_irq = 1'b0;
    @(negedge clk);
    peek(4'd5, v); chk("R5 fall", v, 32'h08);
    chk("R4 irq via done", 32'(host_irq), 1);

    // R6 clear-on-read mode
    wr(4'd5, 32'hFF);
    peek(4'd5, v); chk("R6 write ignored", v, 32'h08);
    rd(4'd5, v); chk("R6 read value", v, 32'h08);
    peek(4'd5, v); chk("R6 cleared", v, 0);
    chk("R4 irq low", 32'(host_irq), 0);

    // R3 blast, idle, abort
    wr(4'd0, 32'h01);
    peek(4'd5, v); chk("R3 blast", v, 32'h20);
    chk("R3 dma_en kept", 32'(core_dma_en), 1);
    wr(4'd0, 32'h00);
    chk("R3 idle", 32'(core_dma_en), 0);
    wr(4'd0, 32'h02);
    chk("R3 cancel", 32'(core_cancel), 1);
    @(negedge clk);
    chk("R3 cancel one cycle", 32'(core_cancel), 0);

    // R7 write-one-to-clear mode
    wr(4'd8, 32'h0100_0000);
    peek(4'd8, v); chk("R1 bctl", v, 32'h0100_0000);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h03);
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk); core_irq = 1'b0;
    @(negedge clk);
    peek(4'd5, v); chk("R5 done on rise", v, 32'h08);
    chk("R4 done masked", 32'(host_irq), 0);
    rd(4'd5, v); chk("R7 read value", v, 32'h08);
    peek(4'd5, v); chk("R7 read no clear", v, 32'h08);
    wr(4'd5, 32'h00);
    peek(4'd5, v); chk("R7 zero write", v, 32'h08);
    wr(4'd5, 32'h08);
    peek(4'd5, v); chk("R7 w1c", v, 0);

    // R11 unused addresses
    wr(4'd9, 32'hDEAD_BEEF);
    peek(4'd9, v); chk("R11 read zero", v, 0);
    peek(4'd8, v); chk("R11 no side write", v, 32'h0100_0000);

    // Random phase: R8 / R9 against a model
    m_wbc = 0; m_wac = 32'h1000; m_dir = 0;
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        stc = 32'($urandom_range(0, 16'h3FF));
        spa = $urandom;
        m_dir = 1'($urandom_range(0, 1));
        wr(4'd1, stc); wr(4'd2, spa);
        wr(4'd0, {24'b0, m_dir, 5'b0, 2'b11});
        m_wbc = stc; m_wac = spa;
      end else begin
        bit d;
        logic [31:0] e, len;
        d = 1'($urandom_range(0, 1));
        len = 32'($urandom_range(0, 16'h1FF));
        e = exp_grant(m_wbc, len, d == m_dir);
        xfer(d, len[LEN_W-1:0], ack, g);
        chk("R8 rand ack", 32'(ack), 1);
        chk(d == m_dir ? "R8 rand grant" : "R9 rand grant", g, e);
        m_wbc = m_wbc - e; m_wac = m_wac + e;
        peek(4'd3, v); chk("R8 rand wbc", v, m_wbc);
        peek(4'd4, v); chk("R8 rand wac", v, m_wac);
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule